// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache

This block is a two-way set-associative cache placed between a word-addressed processor port and a simple main-memory port. An 18-bit word address is split into three fields: tag in bits 17..10, set index in bits 9..4, and word offset in bits 3..0. There are 64 sets. Each set holds two lines of 16 words, and every word has its own valid bit.

A lookup takes one cycle. The set index selects both lines of the set. The two stored tags are compared with the request tag, and in the same cycle the addressed word of each line is read out. Only the word from the matching way is forwarded. A read miss fetches the whole line from memory, lowest offset first, and then answers. Every write is written through to memory. A static parameter selects what a write miss does to the cache:

- **Validate:** allocate the line and keep only the written word valid.
- **Around:** leave the cache untouched.
- **Invalidate:** invalidate the line that the write would have displaced.

Each set has one recency bit, which chooses the victim line.

Both the processor and memory request channels are valid/ready. A requester raises valid and holds its fields steady until a cycle in which ready is also high; that cycle is the transfer. The processor request channel is ready only while the cache is idle, so at most one request is in flight. Its response is a single-cycle valid pulse that cannot be back-pressured. The memory read data returns as a single-cycle pulse some cycles after the read request is accepted, in request order.

Top module: `sa2_cache`

## Requirements
- R1: The address fields are tag = addr[17:10], set = addr[9:4] and word = addr[3:0]. Two lines with different tags in the same set are held at once, and at most one way matches a request.
- R2: A read hit raises `cpu_rsp_valid` in the cycle right after the request is accepted. It returns the stored word and makes no memory request.
- R3: A read miss, or a read whose tag matches but whose word is invalid, reads all 16 words of the line from memory. The reads run at offsets 0 to 15 in ascending order. The cache then returns the requested word, and the rest of the line then hits.
- R4: Each set has one recency bit. Using way 0 clears it and using way 1 sets it. A line fill or an allocation goes into the way equal to the complement of the bit, unless the tag already matches a way.
- R5: Every write produces exactly one memory write with the same address and data. The write response is given in the cycle the memory accepts it.
- R6: A write hit updates the cached word, so a following read hits and returns the new data.
- R7: In around mode, a write miss leaves both lines of the set unchanged and allocates nothing.
- R8: In validate mode, a write miss loads the tag into the victim way and marks only the written word valid, without any memory read. A read of any other word of that line then refills the line.
- R9: In invalidate mode, a write miss marks the victim way's line invalid and does not allocate the written address.
- R10: After reset every line is invalid and `cpu_req_ready` is high, so the first read to any address misses.
- R11: `cpu_req_ready` is low from the acceptance of a request until its response, including throughout a line fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 18 | Word address |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | 32 | Read data, valid with the pulse on reads |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 18 | Memory word address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Read data pulse from memory |
| mem_rsp_rdata | input | 32 | Read data from memory |

## Verification
The assertions assume the following about the memory side:

- It returns exactly one data pulse per accepted read and never one without a pending read.
- A processor requester does not retract a request before it is accepted.

The bench memory meets these assumptions directly. It answers each accepted read one cycle later and toggles its ready every cycle, so both stalled and accepted memory requests occur. It also issues processor requests only from a single task that holds valid until ready is seen.

// File: rtl/wcache_pkg.sv
package wcache_pkg;
  typedef enum logic [1:0] {
    WM_VALIDATE   = 2'd0,
    WM_AROUND     = 2'd1,
    WM_INVALIDATE = 2'd2
  } wmiss_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WMEM,
    ST_FREQ,
    ST_FWAIT,
    ST_RESP
  } state_e;
endpackage

// File: rtl/sa2_way.sv
// Storage for one way: tag per set, valid bit per word, data per word.
module sa2_way #(
  parameter int TAG_W  = 8,
  parameter int SET_W  = 6,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_line_v,
  output logic              rd_word_v,
  output logic [DATA_W-1:0] rd_data,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tag_en,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic              vclr
);
  localparam int SETS  = 1 << SET_W;
  localparam int WORDS = 1 << OFF_W;
  localparam logic [WORDS-1:0] ONE = WORDS'(1);

  logic [TAG_W-1:0]  tags  [SETS];
  logic [WORDS-1:0]  vbits [SETS];
  logic [DATA_W-1:0] words [SETS*WORDS];

  // valid clear is applied before the written word's bit is set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vbits[s] <= '0;
    end else if (vclr || wr_en) begin
      vbits[wr_set] <= (vclr ? '0 : vbits[wr_set]) | (wr_en ? (ONE << wr_off) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (tag_en) tags[wr_set] <= tag_in;
    if (wr_en)  words[{wr_set, wr_off}] <= wr_data;
  end

  assign rd_tag    = tags[rd_set];
  assign rd_line_v = |vbits[rd_set];
  assign rd_word_v = vbits[rd_set][rd_off];
  assign rd_data   = words[{rd_set, rd_off}];
endmodule

// File: rtl/sa2_pick.sv
// Parallel tag compare and way select.
module sa2_pick #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic [TAG_W-1:0]       req_tag,
  input  logic [1:0][TAG_W-1:0]  way_tag,
  input  logic [1:0]             line_v,
  input  logic [1:0]             word_v,
  input  logic [1:0][DATA_W-1:0] way_data,
  output logic [1:0]             tag_hit,
  output logic                   any_hit,
  output logic                   word_hit,
  output logic                   hit_way,
  output logic [DATA_W-1:0]      hit_data
);
  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign tag_hit[w] = line_v[w] && (way_tag[w] == req_tag);
  end

  assign any_hit  = |tag_hit;
  assign word_hit = |(tag_hit & word_v);
  assign hit_way  = tag_hit[1];
  assign hit_data = tag_hit[1] ? way_data[1] : way_data[0];
endmodule

// File: rtl/sa2_lru.sv
// One recency bit per set: holds the way used last.
module sa2_lru #(
  parameter int SET_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic             last_way,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic             upd_way
);
  localparam int SETS = 1 << SET_W;
  logic [SETS-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits_q <= '0;
    else if (upd_en) bits_q[upd_set] <= upd_way;
  end

  assign last_way = bits_q[rd_set];
endmodule

// File: rtl/sa2_cache.sv
module sa2_cache
  import wcache_pkg::*;
#(
  parameter int     TAG_W  = 8,
  parameter int     SET_W  = 6,
  parameter int     OFF_W  = 4,
  parameter int     DATA_W = 32,
  parameter wmiss_e WMISS  = WM_VALIDATE
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cpu_req_valid,
  output logic                           cpu_req_ready,
  input  logic                           cpu_req_we,
  input  logic [TAG_W+SET_W+OFF_W-1:0]   cpu_req_addr,
  input  logic [DATA_W-1:0]              cpu_req_wdata,
  output logic                           cpu_rsp_valid,
  output logic [DATA_W-1:0]              cpu_rsp_rdata,
  output logic                           mem_req_valid,
  input  logic                           mem_req_ready,
  output logic                           mem_req_we,
  output logic [TAG_W+SET_W+OFF_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0]              mem_req_wdata,
  input  logic                           mem_rsp_valid,
  input  logic [DATA_W-1:0]              mem_rsp_rdata
);
  localparam int ADDR_W = TAG_W + SET_W + OFF_W;
  localparam logic [OFF_W-1:0] LAST = '1;

  state_e state, state_d;
  logic              q_we;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [DATA_W-1:0] rsp_q;
  logic [OFF_W-1:0]  fill_cnt;
  logic              fill_way, fill_next_way, fill_start;

  wire [TAG_W-1:0] q_tag = q_addr[ADDR_W-1 -: TAG_W];
  wire [SET_W-1:0] q_set = q_addr[OFF_W +: SET_W];
  wire [OFF_W-1:0] q_off = q_addr[OFF_W-1:0];

  logic [1:0][TAG_W-1:0]  way_tag;
  logic [1:0]             line_v, word_v;
  logic [1:0][DATA_W-1:0] way_data;
  logic [1:0]             way_wr, way_tag_en, way_vclr;
  logic [1:0]             tag_hit;
  logic                   any_hit, word_hit, hit_way;
  logic [DATA_W-1:0]      hit_data;
  logic                   last_way, victim, lru_upd, lru_way;

  wire               filling = (state == ST_FWAIT);
  wire [OFF_W-1:0]   wr_off  = filling ? fill_cnt : q_off;
  wire [DATA_W-1:0]  wr_data = filling ? mem_rsp_rdata : q_wdata;

  for (genvar w = 0; w < 2; w++) begin : g_way
    sa2_way #(.TAG_W(TAG_W), .SET_W(SET_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_way (
      .clk(clk), .rst_n(rst_n),
      .rd_set(q_set), .rd_off(q_off),
      .rd_tag(way_tag[w]), .rd_line_v(line_v[w]), .rd_word_v(word_v[w]), .rd_data(way_data[w]),
      .wr_set(q_set), .wr_off(wr_off), .wr_en(way_wr[w]), .wr_data(wr_data),
      .tag_en(way_tag_en[w]), .tag_in(q_tag), .vclr(way_vclr[w])
    );
  end

  sa2_pick #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_pick (
    .req_tag(q_tag), .way_tag(way_tag), .line_v(line_v), .word_v(word_v),
    .way_data(way_data), .tag_hit(tag_hit), .any_hit(any_hit),
    .word_hit(word_hit), .hit_way(hit_way), .hit_data(hit_data)
  );

  sa2_lru #(.SET_W(SET_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .rd_set(q_set), .last_way(last_way),
    .upd_en(lru_upd), .upd_set(q_set), .upd_way(lru_way)
  );

  assign victim        = ~last_way;
  assign cpu_req_ready = (state == ST_IDLE);
  assign cpu_rsp_rdata = (state == ST_LOOK) ? hit_data : rsp_q;
  assign mem_req_wdata = q_wdata;

  always_comb begin
    state_d       = state;
    way_wr        = '0;
    way_tag_en    = '0;
    way_vclr      = '0;
    lru_upd       = 1'b0;
    lru_way       = 1'b0;
    fill_start    = 1'b0;
    fill_next_way = any_hit ? hit_way : victim;
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = q_addr;
    cpu_rsp_valid = 1'b0;
    unique case (state)
      ST_IDLE: if (cpu_req_valid) state_d = ST_LOOK;
      ST_LOOK: begin
        if (!q_we) begin
          if (word_hit) begin
            cpu_rsp_valid = 1'b1;
            lru_upd       = 1'b1;
            lru_way       = hit_way;
            state_d       = ST_IDLE;
          end else begin
            way_tag_en[fill_next_way] = 1'b1;
            way_vclr[fill_next_way]   = 1'b1;
            fill_start                = 1'b1;
            state_d                   = ST_FREQ;
          end
        end else begin
          state_d = ST_WMEM;
          if (any_hit) begin
            way_wr[hit_way] = 1'b1;
            lru_upd         = 1'b1;
            lru_way         = hit_way;
          end else if (WMISS == WM_VALIDATE) begin
            way_tag_en[victim] = 1'b1;
            way_vclr[victim]   = 1'b1;
            way_wr[victim]     = 1'b1;
            lru_upd            = 1'b1;
            lru_way            = victim;
          end else if (WMISS == WM_INVALIDATE) begin
            way_vclr[victim] = 1'b1;
          end
        end
      end
      ST_WMEM: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        cpu_rsp_valid = mem_req_ready;
        if (mem_req_ready) state_d = ST_IDLE;
      end
      ST_FREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = {q_tag, q_set, fill_cnt};
        if (mem_req_ready) state_d = ST_FWAIT;
      end
      ST_FWAIT: begin
        if (mem_rsp_valid) begin
          way_wr[fill_way] = 1'b1;
          if (fill_cnt == LAST) begin
            lru_upd = 1'b1;
            lru_way = fill_way;
            state_d = ST_RESP;
          end else begin
            state_d = ST_FREQ;
          end
        end
      end
      ST_RESP: begin
        cpu_rsp_valid = 1'b1;
        state_d       = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      fill_cnt <= '0;
      fill_way <= 1'b0;
    end else begin
      state <= state_d;
      if (fill_start) begin
        fill_cnt <= '0;
        fill_way <= fill_next_way;
      end else if (filling && mem_rsp_valid) begin
        fill_cnt <= fill_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_req_valid && cpu_req_ready) begin
      q_we    <= cpu_req_we;
      q_addr  <= cpu_req_addr;
      q_wdata <= cpu_req_wdata;
    end
    if (filling && mem_rsp_valid && fill_cnt == q_off) rsp_q <= mem_rsp_rdata;
  end
endmodule

// File: rtl/sa2_cache_chk.sv
module sa2_cache_chk #(
  parameter int ADDR_W = 18,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [1:0]        tag_hit
);
  logic [ADDR_W-1:0] prev_rd;
  wire rd_xfer = mem_req_valid && mem_req_ready && !mem_req_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_rd <= '0;
    else if (rd_xfer) prev_rd <= mem_req_addr;
  end

  // R11: no second request is taken right after one is accepted
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

  // R11: a response never coincides with readiness for a new request
  a_r11_rsp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !cpu_req_ready);

  // R2: every response is a single-cycle pulse
  a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  // R5: a stalled memory request holds its command and address
  a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr)));

  // R3: fill reads climb one word at a time inside the line
  a_r3_fill_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_xfer && mem_req_addr[OFF_W-1:0] != '0) |->
      (mem_req_addr == ADDR_W'(prev_rd + 1'b1)));

  // R1: at most one way can match a request tag
  a_r1_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tag_hit));
endmodule

bind sa2_cache sa2_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .tag_hit(tag_hit)
);

// File: tb/tb_sa2_cache.sv
`timescale 1ns/1ps
module tb_sa2_cache;
  import wcache_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // index 0: validate, 1: around, 2: invalidate
  logic        req_v [3];
  logic        req_rdy [3];
  logic        req_we [3];
  logic [17:0] req_a [3];
  logic [31:0] req_d [3];
  logic        rsp_v [3];
  logic [31:0] rsp_d [3];
  logic        m_v [3];
  logic        m_rdy [3];
  logic        m_we [3];
  logic [17:0] m_a [3];
  logic [31:0] m_wd [3];
  logic        m_rv [3];
  logic [31:0] m_rd [3];

  for (genvar g = 0; g < 3; g++) begin : g_env
    localparam wmiss_e M = (g == 0) ? WM_VALIDATE : (g == 1) ? WM_AROUND : WM_INVALIDATE;
    sa2_cache #(.WMISS(M)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(req_v[g]), .cpu_req_ready(req_rdy[g]), .cpu_req_we(req_we[g]),
      .cpu_req_addr(req_a[g]), .cpu_req_wdata(req_d[g]),
      .cpu_rsp_valid(rsp_v[g]), .cpu_rsp_rdata(rsp_d[g]),
      .mem_req_valid(m_v[g]), .mem_req_ready(m_rdy[g]), .mem_req_we(m_we[g]),
      .mem_req_addr(m_a[g]), .mem_req_wdata(m_wd[g]),
      .mem_rsp_valid(m_rv[g]), .mem_rsp_rdata(m_rd[g])
    );
  end

  // memory model: base pattern plus written words, ready toggles each cycle
  logic [31:0] wmem [int];
  int          nrd [3];
  int          nwr [3];
  int          ord_err [3];
  logic [17:0] last_rd [3];
  logic [17:0] lw_a [3];
  logic [31:0] lw_d [3];

  function automatic logic [31:0] memval(int i, logic [17:0] a);
    int k = i * 262144 + int'(a);
    return wmem.exists(k) ? wmem[k] : {14'h2A5, a};
  endfunction

  initial begin
    for (int i = 0; i < 3; i++) begin
      req_v[i] = 0; req_we[i] = 0; req_a[i] = '0; req_d[i] = '0;
      m_rdy[i] = 1; m_rv[i] = 0; m_rd[i] = '0;
      nrd[i] = 0; nwr[i] = 0; ord_err[i] = 0; last_rd[i] = '0; lw_a[i] = '0; lw_d[i] = '0;
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      m_rv[i] <= 1'b0;
      if (rst_n && m_v[i] && m_rdy[i]) begin
        if (m_we[i]) begin
          wmem[i * 262144 + int'(m_a[i])] = m_wd[i];
          nwr[i] <= nwr[i] + 1;
          lw_a[i] <= m_a[i];
          lw_d[i] <= m_wd[i];
        end else begin
          m_rv[i] <= 1'b1;
          m_rd[i] <= memval(i, m_a[i]);
          nrd[i] <= nrd[i] + 1;
          if (m_a[i][3:0] != 4'd0 && m_a[i] != last_rd[i] + 18'd1) ord_err[i] <= ord_err[i] + 1;
          last_rd[i] <= m_a[i];
        end
      end
      m_rdy[i] <= rst_n ? ~m_rdy[i] : 1'b1;
    end
  end

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] ad(input logic [7:0] t, input logic [5:0] s, input logic [3:0] o);
    return {t, s, o};
  endfunction

  // one processor transaction; reports data, latency, memory traffic, busy-ready seen
  task automatic access(input int i, input logic we, input logic [17:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat, output int drd, output int dwr,
                        output bit rdy_busy);
    int r0, w0;
    rdy_busy = 0;
    @(negedge clk);
    req_v[i] = 1; req_we[i] = we; req_a[i] = a; req_d[i] = d;
    while (!req_rdy[i]) @(negedge clk);
    r0 = nrd[i]; w0 = nwr[i];
    @(negedge clk);
    req_v[i] = 0;
    lat = 1;
    while (!rsp_v[i] && lat < 500) begin
      if (req_rdy[i]) rdy_busy = 1;
      @(negedge clk);
      lat++;
    end
    rd = rsp_d[i];
    @(posedge clk); #1;
    drd = nrd[i] - r0;
    dwr = nwr[i] - w0;
  endtask

  logic [31:0] rd;
  int lat, drd, dwr;
  bit rb;

  task automatic t_reset();
    chk(req_rdy[0] && req_rdy[1] && req_rdy[2], "R10", "ready after reset", 32'(req_rdy[0]), 1);
    access(0, 0, ad(8'h12, 6'd5, 4'd7), '0, rd, lat, drd, dwr, rb);
    chk(drd == 16, "R10", "first read misses", drd, 16);
    chk(rd == memval(0, ad(8'h12, 6'd5, 4'd7)), "R3", "fill returns word", rd, memval(0, ad(8'h12, 6'd5, 4'd7)));
    chk(ord_err[0] == 0, "R3", "fill order", ord_err[0], 0);
    chk(!rb, "R11", "ready low during fill", 32'(rb), 0);
  endtask

  task automatic t_hit();
    access(0, 0, ad(8'h12, 6'd5, 4'd0), '0, rd, lat, drd, dwr, rb);
    chk(lat == 1 && drd == 0, "R2", "hit latency", lat, 1);
    chk(rd == memval(0, ad(8'h12, 6'd5, 4'd0)), "R2", "hit word 0", rd, memval(0, ad(8'h12, 6'd5, 4'd0)));
    access(0, 0, ad(8'h12, 6'd5, 4'd15), '0, rd, lat, drd, dwr, rb);
    chk(lat == 1 && rd == memval(0, ad(8'h12, 6'd5, 4'd15)), "R3", "rest of line hits", rd, memval(0, ad(8'h12, 6'd5, 4'd15)));
    access(0, 0, ad(8'h12, 6'd6, 4'd0), '0, rd, lat, drd, dwr, rb);
    chk(drd == 16, "R1", "other set index misses", drd, 16);
  endtask

  task automatic t_lru();
    access(1, 0, ad(8'h01, 6'd9, 4'd1), '0, rd, lat, drd, dwr, rb);
    access(1, 0, ad(8'h02, 6'd9, 4'd1), '0, rd, lat, drd, dwr, rb);
    access(1, 0, ad(8'h01, 6'd9, 4'd2), '0, rd, lat, drd, dwr, rb);
    chk(drd == 0 && lat == 1, "R1", "two tags in one set", drd, 0);
    access(1, 0, ad(8'h02, 6'd9, 4'd2), '0, rd, lat, drd, dwr, rb);
    chk(drd == 0 && rd == memval(1, ad(8'h02, 6'd9, 4'd2)), "R1", "second way data", rd, memval(1, ad(8'h02, 6'd9, 4'd2)));
    access(1, 0, ad(8'h01, 6'd9, 4'd3), '0, rd, lat, drd, dwr, rb);
    access(1, 0, ad(8'h03, 6'd9, 4'd0), '0, rd, lat, drd, dwr, rb);
    chk(drd == 16, "R4", "third tag fills", drd, 16);
    access(1, 0, ad(8'h01, 6'd9, 4'd4), '0, rd, lat, drd, dwr, rb);
    chk(drd == 0, "R4", "recent line kept", drd, 0);
    access(1, 0, ad(8'h02, 6'd9, 4'd4), '0, rd, lat, drd, dwr, rb);
    chk(drd == 16, "R4", "older line evicted", drd, 16);
  endtask

  task automatic t_write_hit();
    access(0, 1, ad(8'h12, 6'd5, 4'd7), 32'hDEADBEEF, rd, lat, drd, dwr, rb);
    chk(dwr == 1 && drd == 0, "R5", "one memory write", dwr, 1);
    chk(lw_a[0] == ad(8'h12, 6'd5, 4'd7) && lw_d[0] == 32'hDEADBEEF, "R5", "write-through data", lw_d[0], 32'hDEADBEEF);
    access(0, 0, ad(8'h12, 6'd5, 4'd7), '0, rd, lat, drd, dwr, rb);
    chk(lat == 1 && rd == 32'hDEADBEEF, "R6", "read after write hit", rd, 32'hDEADBEEF);
  endtask

  task automatic t_around();
    // set 9 of dut 1 holds tags 01 and 02 now
    access(1, 1, ad(8'h04, 6'd9, 4'd2), 32'h0A0A0A0A, rd, lat, drd, dwr, rb);
    chk(dwr == 1 && drd == 0, "R7", "miss goes to memory only", dwr, 1);
    access(1, 0, ad(8'h01, 6'd9, 4'd2), '0, rd, lat, drd, dwr, rb);
    chk(drd == 0 && lat == 1, "R7", "way with tag 01 intact", drd, 0);
    access(1, 0, ad(8'h02, 6'd9, 4'd5), '0, rd, lat, drd, dwr, rb);
    chk(drd == 0 && lat == 1, "R7", "way with tag 02 intact", drd, 0);
    access(1, 0, ad(8'h04, 6'd9, 4'd2), '0, rd, lat, drd, dwr, rb);
    chk(drd == 16 && rd == 32'h0A0A0A0A, "R7", "no allocation", rd, 32'h0A0A0A0A);
  endtask

  task automatic t_validate();
    access(0, 0, ad(8'h10, 6'd20, 4'd0), '0, rd, lat, drd, dwr, rb);
    access(0, 1, ad(8'h11, 6'd20, 4'd3), 32'h55AA1234, rd, lat, drd, dwr, rb);
    chk(drd == 0 && dwr == 1, "R8", "no fetch on write miss", drd, 0);
    access(0, 0, ad(8'h11, 6'd20, 4'd3), '0, rd, lat, drd, dwr, rb);
    chk(lat == 1 && rd == 32'h55AA1234, "R8", "written word hits", rd, 32'h55AA1234);
    access(0, 0, ad(8'h10, 6'd20, 4'd9), '0, rd, lat, drd, dwr, rb);
    chk(drd == 0, "R4", "victim was other way", drd, 0);
    access(0, 0, ad(8'h11, 6'd20, 4'd4), '0, rd, lat, drd, dwr, rb);
    chk(drd == 16 && rd == memval(0, ad(8'h11, 6'd20, 4'd4)), "R8", "other word refills", drd, 16);
    access(0, 0, ad(8'h11, 6'd20, 4'd3), '0, rd, lat, drd, dwr, rb);
    chk(lat == 1 && rd == 32'h55AA1234, "R8", "written word after refill", rd, 32'h55AA1234);
  endtask

  task automatic t_invalidate();
    access(2, 0, ad(8'h20, 6'd30, 4'd0), '0, rd, lat, drd, dwr, rb);
    access(2, 0, ad(8'h21, 6'd30, 4'd0), '0, rd, lat, drd, dwr, rb);
    access(2, 1, ad(8'h22, 6'd30, 4'd6), 32'hCAFEF00D, rd, lat, drd, dwr, rb);
    chk(dwr == 1 && drd == 0, "R9", "write miss to memory", dwr, 1);
    access(2, 0, ad(8'h21, 6'd30, 4'd1), '0, rd, lat, drd, dwr, rb);
    chk(drd == 0 && lat == 1, "R9", "recent way kept", drd, 0);
    access(2, 0, ad(8'h20, 6'd30, 4'd1), '0, rd, lat, drd, dwr, rb);
    chk(drd == 16, "R9", "victim line invalidated", drd, 16);
    access(2, 0, ad(8'h22, 6'd30, 4'd6), '0, rd, lat, drd, dwr, rb);
    chk(drd == 16 && rd == 32'hCAFEF00D, "R9", "written line not allocated", rd, 32'hCAFEF00D);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_hit();
    t_lru();
    t_write_hit();
    t_around();
    t_validate();
    t_invalidate();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule